// File: doc/BRIEF.md
# Dual-Mode Dual-Port Nibble RAM

A small memory of 32 words by 4 bits. It has a separate write address and read address, so one word can be written while another is read. A strap input, `async_mode`, picks how the block keeps time. When it is 0, the block is a clocked RAM: writes and read captures happen on the rising edge of `clk`. When it is 1, the block is a level-sensitive RAM. While `ld` is high, the address path and the storage are transparent. A word follows `din` for as long as its write is open, and the read port follows the read address with no clock.

The load strobe `ld` qualifies everything. No write happens while `ld` is low. The read address is held while `ld` is low. The write strobe `we_n` is active low. The read data is forced to zero whenever `oe` is low. A clear pulse `clr` wipes the whole array, and it wins over a write issued at the same time. `async_mode` is meant to be set once after reset. Each timing mode keeps its own copy of the storage, so a clear should follow any change of mode.

Top module: `nibble_dpram`

## Requirements
- R1: The array holds 2**AW words of DW bits (32 x 4 by default), and the read address and write address are fully independent inputs.
- R2: With async_mode=0, at a rising clk edge where ld=1, we_n=0 and clr=0, the word at wa takes the value of din.
- R3: In both modes, no word changes while ld=0 or we_n=1 (clr=0).
- R4: With async_mode=0, at a rising edge where ld=1, the read register takes the word at ra as it stood before that edge. A read and a write to the same address at one edge therefore return the old data. dout shows the read register while oe=1.
- R5: With async_mode=0, the read register holds its value at edges where ld=0, whatever ra does.
- R6: With async_mode=1, ld=1 and we_n=0, the word at wa follows din with no clock. It keeps the last value once ld rises to 1 no more (ld=0) or we_n=1.
- R7: With async_mode=1, dout follows the word at ra combinationally while ld=1. While ld=0 the read address is held at its last value.
- R8: While oe=0, dout is all zeros.
- R9: With async_mode=0, a rising edge with clr=1 sets every word to zero, even when a write is requested at that edge. With async_mode=1, every word reads zero while clr=1.
- R10: After rst_n is released, in synchronous mode with oe=1, dout is zero until the first read capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for synchronous mode |
| rst_n | input | 1 | Active-low reset of the read register |
| async_mode | input | 1 | 0 = clocked RAM, 1 = transparent latch RAM |
| ld | input | 1 | Load strobe qualifying addresses and writes |
| we_n | input | 1 | Active-low write enable |
| wa | input | AW | Write address |
| ra | input | AW | Read address |
| din | input | DW | Write data |
| oe | input | 1 | Output enable for dout |
| clr | input | 1 | Clear command, zeroes every word |
| dout | output | DW | Read data, zero when oe=0 |

## Verification
The bench builds the block with its default parameters: a 5-bit address and a 4-bit word. At this small depth, both end addresses, 0 and 31, can be written and read back directly. A clear can then be confirmed across several distant words in a few cycles. Both timing modes are driven in one run. The synchronous half checks the same-address collision and the held read address. The asynchronous half checks the data path with no clock edge involved.

// File: rtl/nibble_dpram.sv
`timescale 1ns/1ps
module nibble_dpram #(
  parameter int AW = 5,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          async_mode,
  input  logic          ld,
  input  logic          we_n,
  input  logic [AW-1:0] wa,
  input  logic [AW-1:0] ra,
  input  logic [DW-1:0] din,
  input  logic          oe,
  input  logic          clr,
  output logic [DW-1:0] dout
);
  localparam int DEPTH = 1 << AW;

  logic [DEPTH*DW-1:0] mem_q;
  logic [DEPTH*DW-1:0] mem_l;
  logic [DEPTH-1:0]    wen_l;
  logic [DW-1:0]       rd_q;
  logic [AW-1:0]       ra_l;

  always_ff @(posedge clk)
    if (!async_mode) begin
      if (clr) mem_q <= '0;
      else if (ld && !we_n) mem_q[wa*DW +: DW] <= din;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rd_q <= '0;
    else if (!async_mode && ld) rd_q <= mem_q[ra*DW +: DW];

  always_comb
    for (int i = 0; i < DEPTH; i++)
      wen_l[i] = async_mode && (clr || (ld && !we_n && wa == AW'(i)));

  always_latch
    for (int i = 0; i < DEPTH; i++)
      if (wen_l[i]) mem_l[i*DW +: DW] <= clr ? '0 : din;

  always_latch
    if (ld) ra_l <= ra;

  assign dout = !oe ? '0 : async_mode ? mem_l[ra_l*DW +: DW] : rd_q;

  // R2
  sync_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!async_mode && ld && !we_n && !clr) |=> (mem_q[DW*$past(wa) +: DW] == $past(din)));

  // R3
  sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!async_mode && (!ld || we_n) && !clr) |=> $stable(mem_q));

  // R9
  sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!async_mode && clr) |=> (mem_q == '0));

  // R4
  sync_read_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!async_mode && ld) |=> (rd_q == $past(mem_q[ra*DW +: DW])));

  // R5
  sync_rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!async_mode && !ld) |=> $stable(rd_q));

  // R7
  async_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (async_mode && oe && ld && !we_n && !clr && wa == ra) |-> (dout == din));

  // R8
  oe_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> (dout == '0));
endmodule

// File: tb/sim_nibble_dpram.sv
`timescale 1ns/1ps
module sim_nibble_dpram;
  logic clk = 0, rst_n = 0, async_mode = 0, ld = 0, we_n = 1, oe = 0, clr = 0;
  logic [4:0] wa = '0, ra = '0;
  logic [3:0] din = '0;
  logic [3:0] dout;
  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  nibble_dpram #(.AW(5), .DW(4)) u0 (
    .clk(clk), .rst_n(rst_n), .async_mode(async_mode), .ld(ld), .we_n(we_n),
    .wa(wa), .ra(ra), .din(din), .oe(oe), .clr(clr), .dout(dout));

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: dout=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle();
    ld = 0; we_n = 1; clr = 0;
  endtask

  task automatic swr(logic [4:0] a, logic [3:0] d);
    ld = 1; we_n = 0; wa = a; din = d; tick(); idle();
  endtask

  task automatic srd(logic [4:0] a);
    ld = 1; we_n = 1; ra = a; tick(); idle();
  endtask

  task automatic t_reset();
    oe = 1; #1;
    chk("R10 reset", dout, 4'h0);
  endtask

  task automatic t_sync_basic();
    swr(5'd0, 4'h3); swr(5'd31, 4'hC); swr(5'd9, 4'h6);
    srd(5'd0);  chk("R2 addr0", dout, 4'h3);
    srd(5'd31); chk("R1 addr31", dout, 4'hC);
    srd(5'd9);  chk("R2 addr9", dout, 4'h6);
  endtask

  task automatic t_collision();
    swr(5'd4, 4'hA);
    ld = 1; we_n = 0; wa = 5'd4; din = 4'h5; ra = 5'd4; tick(); idle();
    chk("R4 old data", dout, 4'hA);
    srd(5'd4); chk("R4 new data", dout, 4'h5);
  endtask

  task automatic t_no_write();
    ld = 0; we_n = 0; wa = 5'd9; din = 4'hF; tick(); idle();
    ld = 1; we_n = 1; wa = 5'd9; din = 4'hE; tick(); idle();
    srd(5'd9); chk("R3 sync no write", dout, 4'h6);
  endtask

  task automatic t_rd_hold();
    srd(5'd4);
    ra = 5'd0; ld = 0; tick(); tick();
    chk("R5 read hold", dout, 4'h5);
  endtask

  task automatic t_oe();
    oe = 0; #1;
    chk("R8 oe low", dout, 4'h0);
    oe = 1; #1;
    chk("R8 oe high", dout, 4'h5);
  endtask

  task automatic t_clear();
    ld = 1; we_n = 0; wa = 5'd12; din = 4'hF; clr = 1; tick(); idle();
    srd(5'd12); chk("R9 clear beats write", dout, 4'h0);
    srd(5'd31); chk("R9 clear addr31", dout, 4'h0);
    srd(5'd0);  chk("R9 clear addr0", dout, 4'h0);
  endtask

  task automatic t_async();
    async_mode = 1; clr = 1; #1; clr = 0; #1;
    ld = 1; we_n = 0; wa = 5'd7; ra = 5'd7; din = 4'h9; #1;
    chk("R6 async write through", dout, 4'h9);
    din = 4'h2; #1;
    chk("R7 async follows", dout, 4'h2);
    we_n = 1; #1; din = 4'hB; #1;
    chk("R6 async holds", dout, 4'h2);
    ld = 0; we_n = 0; wa = 5'd7; din = 4'hD; #1;
    chk("R3 async no write", dout, 4'h2);
    we_n = 1; ra = 5'd3; #1;
    chk("R7 async addr held", dout, 4'h2);
    ld = 1; #1;
    chk("R7 async addr moves", dout, 4'h0);
    ra = 5'd7; #1;
    clr = 1; #1;
    chk("R9 async clear", dout, 4'h0);
    clr = 0; ld = 0; #1;
    async_mode = 0;
  endtask

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog: dout=%h expected=done", dout);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_sync_basic();
    t_collision();
    t_no_write();
    t_rd_hold();
    t_oe();
    t_clear();
    @(negedge clk);
    t_async();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule